// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers event pulses from several interrupt sources, keeps a request flag for each one and gates every flag twice: once by the source's own enable bit and once by a single global enable. Among the requests that pass both gates it picks the winner by fixed priority and presents the matching vector address together with a request line to the processor core. Most sources own a vector slot. Two timer compare sources, compare-P and compare-A, share one multi-function slot. That slot has its own second-level register holding their flags and enables.

Software reaches the flag and enable state through a small register port. The core takes a pending interrupt by pulsing an acknowledge while the request line is high, and it loads the presented vector in that same cycle. Acceptance clears the global enable so that the service routine cannot be interrupted. The return strobe sets the enable again. Events that arrive while the enable is clear are still latched and wait for service.

Register map, with `regAddr` 2 bits wide and `wrData`/`rdData` 8 bits wide:

- Address 0 is the global enable, at bit 0.
- Address 1 holds the per-slot enables. Bits 0 to NUM_IND-1 are the individual sources and bit NUM_IND is the multi-function slot.
- Address 2 holds the individual flags in bits 0 to NUM_IND-1. Bit NUM_IND is a read-only copy of the multi-function request.
- Address 3 is the multi-function register: bit 5 is the compare-A flag, bit 4 the compare-P flag, bit 1 the compare-A enable and bit 0 the compare-P enable.

Top module: `irqc_top`

## Requirements
- R1: After reset every flag, every enable and the global enable are 0, all four registers read 0, `irqReq` is 0 and `vecAddr` is 0.
- R2: An event pulse on a source sets that source's flag on the next clock edge, whatever the state of its enable bit or of the global enable.
- R3: `irqReq` is 1 only when the global enable is 1 and at least one slot has both its flag and its enable at 1. A flag whose enable is 0 stays set and raises no request.
- R4: Slot i means individual source i for i < NUM_IND, and slot NUM_IND means the multi-function group. The lowest-numbered requesting slot wins, and `vecAddr` = VEC_BASE + slot × VEC_STRIDE (4, 8, 12 and 16 with the defaults).
- R5: The multi-function slot requests when its slot enable (address 1, bit NUM_IND) is 1 and at least one sub-flag has its sub-enable at 1. Address 2 bit NUM_IND reads back this sub-request.
- R6: At address 3, bits 7, 6, 3 and 2 always read 0 and writes to them are ignored. Bits 5, 4, 1 and 0 hold the values written to them.
- R7: An `irqAck` pulse while `irqReq` is 1 clears the global enable on that edge. If the winner is an individual source, its flag is cleared as well. The multi-function sub-flags are left unchanged.
- R8: Events that arrive while the global enable is 0 stay latched and are serviced in priority order once the enable returns to 1.
- R9: A `retStrobe` pulse sets the global enable to 1 unless an acceptance happens in the same cycle. Acceptance takes precedence over the return strobe, and the return strobe takes precedence over a software write to address 0.
- R10: A software write to a flag register sets each flag to the written value, except that an event pulse in the same cycle leaves that flag at 1.
- R11: An `irqAck` pulse while `irqReq` is 0 changes no flag and no enable.
- R12: While `irqReq` is 0, `vecAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evtInd | input | NUM_IND | Event pulses of the individual-vector sources |
| evtMfP | input | 1 | Compare-P event pulse (multi-function group) |
| evtMfA | input | 1 | Compare-A event pulse (multi-function group) |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for reads and writes |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for `regAddr` (combinational) |
| irqAck | input | 1 | Core accepts the presented interrupt |
| retStrobe | input | 1 | Core returns from a service routine |
| irqReq | output | 1 | Interrupt request to the core |
| vecAddr | output | VEC_W | Vector address of the winning slot |

## Verification
A flag latch that is wrong shows up on the register read port in the cycle after the event that should have set it. When the enables are set, the same fault also shows as a missing or extra request. A fault in the priority encoder shows at once as a wrong `vecAddr` for one particular pattern of pending slots. For that reason the bench sweeps all sixteen flag patterns and all sixteen enable patterns. A global enable left in the wrong state after an acknowledge or return is visible on `irqReq` and at address 0 one cycle later. An acceptance that clears the wrong flag is found when the remaining requests are served in order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_GIE  = 0;
  localparam int ADDR_EN   = 1;
  localparam int ADDR_FLAG = 2;
  localparam int ADDR_SUB  = 3;

  // bit positions inside the multi-function register
  localparam int SUB_FLAG_A = 5;
  localparam int SUB_FLAG_P = 4;
  localparam int SUB_EN_A   = 1;
  localparam int SUB_EN_P   = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrValid;
    logic [2:0] clrIdx;
  } irqc_strobe_t;
endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_IND = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IND-1:0] evtInd,
  input  logic               evtMfP,
  input  logic               evtMfA,
  input  logic               wrEn,
  input  logic [1:0]         regAddr,
  input  logic [7:0]         wrData,
  input  logic               gieQ,
  input  irqc_strobe_t       strobe,
  output logic [7:0]         rdData,
  output logic [NUM_IND:0]   pendVec,
  output logic               gieWrEn,
  output logic               gieWrVal
);
  localparam int NSLOT = NUM_IND + 1;

  logic [NUM_IND-1:0] flagQ, flagD, clrMask;
  logic [NSLOT-1:0]   enQ;
  logic [1:0]         subFlagQ, subFlagD, subEnQ;  // [1]=A, [0]=P
  logic               wrEnReg, wrFlag, wrSub, mfReq;

  assign wrEnReg  = wrEn && (regAddr == 2'(ADDR_EN));
  assign wrFlag   = wrEn && (regAddr == 2'(ADDR_FLAG));
  assign wrSub    = wrEn && (regAddr == 2'(ADDR_SUB));
  assign gieWrEn  = wrEn && (regAddr == 2'(ADDR_GIE));
  assign gieWrVal = wrData[0];

  generate
    for (genvar i = 0; i < NUM_IND; i++) begin : g_clr
      assign clrMask[i] = strobe.clrValid && (strobe.clrIdx == 3'(i));
    end
  endgenerate

  // events always win over writes and acceptance clears
  always_comb begin
    flagD    = (wrFlag ? wrData[NUM_IND-1:0] : (flagQ & ~clrMask)) | evtInd;
    subFlagD = (wrSub ? {wrData[SUB_FLAG_A], wrData[SUB_FLAG_P]} : subFlagQ)
               | {evtMfA, evtMfP};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagQ    <= '0;
      enQ      <= '0;
      subFlagQ <= '0;
      subEnQ   <= '0;
    end else begin
      flagQ    <= flagD;
      subFlagQ <= subFlagD;
      if (wrEnReg) enQ <= wrData[NSLOT-1:0];
      if (wrSub)   subEnQ <= {wrData[SUB_EN_A], wrData[SUB_EN_P]};
    end
  end

  assign mfReq   = |(subFlagQ & subEnQ);
  assign pendVec = {mfReq & enQ[NUM_IND], flagQ & enQ[NUM_IND-1:0]};

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      2'(ADDR_GIE):  rdData[0] = gieQ;
      2'(ADDR_EN):   rdData[NSLOT-1:0] = enQ;
      2'(ADDR_FLAG): rdData[NSLOT-1:0] = {mfReq, flagQ};
      default: begin
        rdData[SUB_FLAG_A] = subFlagQ[1];
        rdData[SUB_FLAG_P] = subFlagQ[0];
        rdData[SUB_EN_A]   = subEnQ[1];
        rdData[SUB_EN_P]   = subEnQ[0];
      end
    endcase
  end

  // R2
  generate
    for (genvar i = 0; i < NUM_IND; i++) begin : g_chk
      evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evtInd[i] |=> flagQ[i]);
    end
  endgenerate

  // R5
  mf_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evtMfA && subEnQ[1] && !wrSub) |=> mfReq);

  // R6
  sub_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == 2'(ADDR_SUB)) |-> (rdData[7:6] == 2'b00 && rdData[3:2] == 2'b00));
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
#(
  parameter int NUM_IND    = 3,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 4,
  parameter int VEC_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IND:0]   pendVec,
  input  logic               irqAck,
  input  logic               retStrobe,
  input  logic               gieWrEn,
  input  logic               gieWrVal,
  output logic               gieQ,
  output logic               irqReq,
  output logic [VEC_W-1:0]   vecAddr,
  output irqc_strobe_t       strobe
);
  localparam int NSLOT  = NUM_IND + 1;
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [SLOT_W-1:0] winIdx;
  logic [NSLOT-1:0]  grant;
  logic              anyPend, accept;

  // fixed priority: lowest slot index wins
  always_comb begin
    winIdx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (pendVec[i]) winIdx = SLOT_W'(i);
    end
    anyPend = |pendVec;
    grant   = '0;
    if (anyPend) grant[winIdx] = 1'b1;
  end

  assign irqReq  = gieQ && anyPend;
  assign accept  = irqAck && irqReq;
  assign vecAddr = irqReq ? (VEC_W'(VEC_BASE) + VEC_W'(winIdx) * VEC_W'(VEC_STRIDE))
                          : '0;

  always_comb begin
    strobe          = '0;
    strobe.clrValid = accept && (int'(winIdx) < NUM_IND);
    strobe.clrIdx   = 3'(winIdx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gieQ <= 1'b0;
    else if (accept)    gieQ <= 1'b0;
    else if (retStrobe) gieQ <= 1'b1;
    else if (gieWrEn)   gieQ <= gieWrVal;
  end

  // R7
  gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqAck && irqReq) |=> !gieQ);

  // R9
  ret_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retStrobe && !irqAck) |=> gieQ);

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> ($countones(grant) == 1));

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqAck && !irqReq && !retStrobe && !gieWrEn) |=> $stable(gieQ));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_IND    = 3,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 4,
  parameter int VEC_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IND-1:0] evtInd,
  input  logic               evtMfP,
  input  logic               evtMfA,
  input  logic               wrEn,
  input  logic [1:0]         regAddr,
  input  logic [7:0]         wrData,
  output logic [7:0]         rdData,
  input  logic               irqAck,
  input  logic               retStrobe,
  output logic               irqReq,
  output logic [VEC_W-1:0]   vecAddr
);
  logic [NUM_IND:0] pendVec;
  logic             gieQ, gieWrEn, gieWrVal;
  irqc_strobe_t     strobe;

  irqc_datapath #(.NUM_IND(NUM_IND)) u_dp (
    .clk(clk), .rst_n(rst_n), .evtInd(evtInd), .evtMfP(evtMfP), .evtMfA(evtMfA),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .gieQ(gieQ), .strobe(strobe),
    .rdData(rdData), .pendVec(pendVec), .gieWrEn(gieWrEn), .gieWrVal(gieWrVal)
  );

  irqc_control #(
    .NUM_IND(NUM_IND), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .pendVec(pendVec), .irqAck(irqAck),
    .retStrobe(retStrobe), .gieWrEn(gieWrEn), .gieWrVal(gieWrVal), .gieQ(gieQ),
    .irqReq(irqReq), .vecAddr(vecAddr), .strobe(strobe)
  );
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int NUM_IND = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_IND-1:0] evtInd = '0;
  logic evtMfP = 1'b0, evtMfA = 1'b0, wrEn = 1'b0, irqAck = 1'b0, retStrobe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, vecAddr;
  logic irqReq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst_n(rst_n), .evtInd(evtInd), .evtMfP(evtMfP), .evtMfA(evtMfA),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .irqAck(irqAck), .retStrobe(retStrobe), .irqReq(irqReq), .vecAddr(vecAddr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    wrEn = 1'b1; regAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rdChk(string tag, logic [1:0] a, logic [7:0] exp);
    regAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic pulseAck();
    irqAck = 1'b1; step(); irqAck = 1'b0; #1;
  endtask

  task automatic pulseRet();
    retStrobe = 1'b1; step(); retStrobe = 1'b0; #1;
  endtask

  function automatic int lowBit(int m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic expReq(string tag, int mask);
    int w;
    w = lowBit(mask);
    #1;
    chk({tag, " req"}, irqReq, (w >= 0));
    chk({tag, " vec"}, vecAddr, (w >= 0) ? 4 + 4 * w : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 irqReq", irqReq, 0);
    chk("R1 vecAddr", vecAddr, 0);
    for (int a = 0; a < 4; a++) rdChk("R1 register", 2'(a), 8'h00);

    // R6 reserved bits of the sub register
    wrReg(2'd3, 8'hFF);
    rdChk("R6 sub readback", 2'd3, 8'h33);
    wrReg(2'd3, 8'h00);
    rdChk("R6 sub cleared", 2'd3, 8'h00);

    // R2 events latch with enables at 0; R3 no request without enable
    wrReg(2'd0, 8'h01);
    for (int i = 0; i < NUM_IND; i++) begin
      evtInd = 3'(1 << i); step(); evtInd = '0;
    end
    rdChk("R2 flags latched", 2'd2, 8'h07);
    #1; chk("R3 no req with enables off", irqReq, 0);
    evtMfA = 1'b1; step(); evtMfA = 1'b0;
    rdChk("R2 mf sub flag latched", 2'd3, 8'h20);
    wrReg(2'd2, 8'h00);
    wrReg(2'd3, 8'h00);

    // R4 sweep of flag patterns with all enables on
    wrReg(2'd1, 8'h0F);
    for (int p = 0; p < 16; p++) begin
      wrReg(2'd2, 8'(p & 7));
      wrReg(2'd3, (p & 8) ? 8'h11 : 8'h00);
      expReq("R4 flag sweep", p);
      rdChk("R5 flag read", 2'd2, 8'(p));
    end
    // R3 sweep of enable patterns with every flag set
    wrReg(2'd2, 8'h07);
    wrReg(2'd3, 8'h11);
    for (int e = 0; e < 16; e++) begin
      wrReg(2'd1, 8'(e));
      expReq("R3 enable sweep", e);
    end
    // R5 sub-enable pairing
    wrReg(2'd1, 8'h08);
    wrReg(2'd3, 8'h22);
    expReq("R5 A flag with A enable", 8);
    wrReg(2'd3, 8'h21);
    expReq("R5 A flag with P enable only", 0);
    rdChk("R5 mf bit clear", 2'd2, 8'h07);

    // R7 acceptance, R12 vector idle
    wrReg(2'd3, 8'h11);
    wrReg(2'd2, 8'h06);
    wrReg(2'd1, 8'h0F);
    expReq("R4 pending 1,2,mf", 14);
    pulseAck();
    chk("R7 req dropped", irqReq, 0);
    chk("R12 vec idle", vecAddr, 0);
    rdChk("R7 gie cleared", 2'd0, 8'h00);
    rdChk("R7 flag1 cleared", 2'd2, 8'h0C);

    // R8 event while blocked
    evtInd = 3'b001; step(); evtInd = '0;
    rdChk("R8 latched while blocked", 2'd2, 8'h0D);
    #1; chk("R8 no req while blocked", irqReq, 0);
    pulseRet();
    rdChk("R9 gie set", 2'd0, 8'h01);
    expReq("R8 serviced slot0", 13);
    pulseAck(); pulseRet();
    expReq("R8 then slot2", 12);
    pulseAck(); pulseRet();
    expReq("R8 then mf", 8);
    pulseAck();
    rdChk("R7 mf sub flags kept", 2'd3, 8'h11);
    rdChk("R7 gie cleared after mf", 2'd0, 8'h00);
    wrReg(2'd3, 8'h01);

    // R9 return beats a software write of 0
    wrEn = 1'b1; regAddr = 2'd0; wrData = 8'h00; retStrobe = 1'b1;
    step(); wrEn = 1'b0; retStrobe = 1'b0;
    rdChk("R9 ret over write", 2'd0, 8'h01);
    wrReg(2'd0, 8'h00);

    // R10 event beats a clearing write
    evtInd = 3'b010; wrEn = 1'b1; regAddr = 2'd2; wrData = 8'h00;
    step(); evtInd = '0; wrEn = 1'b0;
    rdChk("R10 event wins", 2'd2, 8'h02);
    wrReg(2'd2, 8'h00);
    rdChk("R10 write clears", 2'd2, 8'h00);

    // R11 acknowledge with no request
    wrReg(2'd2, 8'h05);
    pulseAck();
    rdChk("R11 flags kept", 2'd2, 8'h05);
    rdChk("R11 enables kept", 2'd1, 8'h0F);
    rdChk("R11 gie kept", 2'd0, 8'h00);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule